// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front-End

This block sits between a host bus and a 16-bit NOR-style memory core whose low address bits travel on the same sixteen wires as the data. A separate active-low address strobe marks when the shared wires hold an address. On the rising edge of that strobe, the block stores the bus value together with five upper address pins as a 21-bit word address. The three active-low control strobes (chip select, output enable, write enable) are synchronised to the sampling clock and filtered. The filtered levels are then decoded into one of four bus cycles: standby, output-disabled, read or write.

During a write, the block follows the shared bus. When either chip select or write enable rises, the last value seen is handed to the core as a single-cycle write pulse, together with the latched address. During a read, the block drives either the array word from the core or a status word with its flags in fixed bit positions. Drive intent is given on a separate enable output, not a true tri-state pin. When that enable is low, the data output is held at zero.

The minimum accepted strobe width `MIN_W` is a parameter counted in sampling-clock cycles (default 3). Every strobe input passes through two synchroniser flops and then the filter. A level change on a strobe pin therefore shows up in the decoded cycle exactly `2 + MIN_W` clock edges after it is applied.

Top module: `muxbus_frontend`

## Requirements
- R1: While reset is held and right after it, `bus_oe` is 0, `cycle` is 0 (standby), `wr_stb` is 0 and `word_addr` is 0.
- R2: When `ale_n` rises, `word_addr` takes `{addr_hi, adq_in}` as they were at that rise. `word_addr` keeps that value until the next rise, whatever `adq_in` does in between.
- R3: The cycle is decoded from the filtered strobes with this encoding: 0 (standby) when `ce_n` is high; 3 (write) when `ce_n` and `we_n` are low and `oe_n` is high; 2 (read) when `ce_n` and `oe_n` are low and `we_n` is high; 1 (output-disabled) otherwise.
- R4: When a write cycle ends because `ce_n` or `we_n` rises, `wr_stb` is high for exactly one clock. At that clock, `wr_data` equals the bus value present just before the first of the two strobes rose, and `word_addr` is the latched address.
- R5: A low or high pulse on `ce_n`, `oe_n` or `we_n` that lasts fewer than `MIN_W` clock samples does not change `cycle` and produces no write. A write-enable pulse of exactly `MIN_W` samples is accepted as a write.
- R6: `bus_oe` is 1 only in a read cycle. In standby it is 0 whatever the levels of `oe_n` and `we_n`. Whenever `bus_oe` is 0, `bus_out` is 0.
- R7: In a read cycle with `status_sel` at 0, `bus_out` equals `rd_word`.
- R8: In a read cycle with `status_sel` at 1, `bus_out` carries `st_poll` on bit 7, `st_toggle[1]` on bit 6, `st_err` on bit 5 and `st_toggle[0]` on bit 2. All other bits are 0.
- R9: When `ce_n`, `oe_n` and `we_n` are all low together, the cycle is output-disabled (1). In that state the bus is not driven and no write is produced.
- R10: A level change on a control strobe pin reaches `cycle` exactly `2 + MIN_W` rising clock edges after it is applied, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adq_in | input | 16 | Shared address/data bus as seen by the block |
| addr_hi | input | 5 | Upper word-address pins |
| ale_n | input | 1 | Address strobe, address taken on its rising edge |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_word | input | 16 | Array data from the memory core |
| status_sel | input | 1 | Read returns the status word instead of array data |
| st_poll | input | 1 | Data-polling flag from the controller |
| st_toggle | input | 2 | Toggle flags, [1] goes to bit 6 and [0] to bit 2 |
| st_err | input | 1 | Error flag from the controller |
| bus_out | output | 16 | Data the block would drive onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| word_addr | output | 21 | Latched word address |
| cycle | output | 2 | Decoded bus cycle |
| wr_stb | output | 1 | One-clock pulse marking a completed write |
| wr_data | output | 16 | Word captured by the completed write |

## Verification
If a filter counter or a synchroniser stage is wrong, the decoded cycle moves one or more edges away from the `2 + MIN_W` point. It may also follow a short pulse it should ignore. In both cases the fault shows on `cycle` and `bus_oe` within a handful of clocks of the strobe change. A stale or early-frozen write buffer only shows when the write ends: `wr_data` then differs from the word the scoreboard queued, so strobe orderings where chip select and write enable rise at different times are needed to expose it. An address register that loads at the wrong moment shows on `word_addr` as soon as the shared bus changes after the address phase.

// File: rtl/muxbus_frontend.sv
module muxbus_frontend #(
  parameter int MIN_W = 3,
  parameter int DW    = 16,
  parameter int HW    = 5,
  localparam int AW   = DW + HW,
  localparam int CW   = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] adq_in,
  input  logic [HW-1:0] addr_hi,
  input  logic          ale_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] rd_word,
  input  logic          status_sel,
  input  logic          st_poll,
  input  logic [1:0]    st_toggle,
  input  logic          st_err,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    cycle,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);

  localparam logic [1:0] CY_STBY = 2'd0;
  localparam logic [1:0] CY_ODIS = 2'd1;
  localparam logic [1:0] CY_RD   = 2'd2;
  localparam logic [1:0] CY_WR   = 2'd3;

  // strobe vector order: [2]=ce, [1]=oe, [0]=we
  logic [2:0]    stb_m, stb_s, stb_f;
  logic [2:0]    ale_sh;
  logic [DW-1:0] adq_m, adq_s, wbuf;
  logic [HW-1:0] hi_m, hi_s;
  logic          was_wr;
  logic [DW-1:0] stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_m  <= 3'b111;
      stb_s  <= 3'b111;
      ale_sh <= 3'b111;
      adq_m  <= '0;
      adq_s  <= '0;
      hi_m   <= '0;
      hi_s   <= '0;
    end else begin
      stb_m  <= {ce_n, oe_n, we_n};
      stb_s  <= stb_m;
      ale_sh <= {ale_sh[1:0], ale_n};
      adq_m  <= adq_in;
      adq_s  <= adq_m;
      hi_m   <= addr_hi;
      hi_s   <= hi_m;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_flt
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b1;
      end else if (stb_s[g] == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(MIN_W - 1)) begin
        cnt <= '0;
        lvl <= stb_s[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign stb_f[g] = lvl;
  end

  always_comb begin
    if (stb_f[2])                    cycle = CY_STBY;
    else if (!stb_f[0] && stb_f[1])  cycle = CY_WR;
    else if (!stb_f[1] && stb_f[0])  cycle = CY_RD;
    else                             cycle = CY_ODIS;
  end

  wire ale_rise = ale_sh[1] && !ale_sh[2];
  wire wr_live  = !stb_s[2] && !stb_s[0] && stb_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_addr <= '0;
      wbuf      <= '0;
      was_wr    <= 1'b0;
    end else begin
      if (ale_rise) word_addr <= {hi_s, adq_s};
      if (wr_live)  wbuf      <= adq_s;
      was_wr <= (cycle == CY_WR);
    end
  end

  always_comb begin
    stat_word    = '0;
    stat_word[7] = st_poll;
    stat_word[6] = st_toggle[1];
    stat_word[5] = st_err;
    stat_word[2] = st_toggle[0];
  end

  assign bus_oe  = (cycle == CY_RD);
  assign bus_out = !bus_oe ? '0 : (status_sel ? stat_word : rd_word);
  assign wr_stb  = was_wr && (cycle != CY_WR);
  assign wr_data = wbuf;

endmodule

// File: rtl/muxbus_frontend_chk.sv
module muxbus_frontend_chk #(
  parameter int DW = 16,
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic [AW-1:0] word_addr,
  input logic [1:0]    cycle,
  input logic          wr_stb,
  input logic          status_sel,
  input logic          addr_load,
  input logic          ce_flt,
  input logic          ce_sync
);

  AST_STBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle == 2'd0) |-> !bus_oe); // R6
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0)); // R6
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R4
  AST_WR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(cycle) == 2'd3)); // R4
  AST_ADDR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_addr) |-> $past(addr_load)); // R2
  AST_FILTER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ce_flt) |-> (ce_flt == $past(ce_sync))); // R5
  AST_STATUS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && status_sel) |-> (bus_out[DW-1:8] == '0 && bus_out[4:3] == 2'b00 && bus_out[1:0] == 2'b00)); // R8

endmodule

bind muxbus_frontend muxbus_frontend_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .word_addr  (word_addr),
  .cycle      (cycle),
  .wr_stb     (wr_stb),
  .status_sel (status_sel),
  .addr_load  (ale_rise),
  .ce_flt     (stb_f[2]),
  .ce_sync    (stb_s[2])
);

// File: tb/muxbus_frontend_test.sv
module muxbus_frontend_test;
  localparam int MIN_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adq_in = '0;
  logic [4:0]  addr_hi = '0;
  logic        ale_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] rd_word = '0;
  logic        status_sel = 1'b0, st_poll = 1'b0, st_err = 1'b0;
  logic [1:0]  st_toggle = '0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [20:0] word_addr;
  logic [1:0]  cycle;
  logic        wr_stb;
  logic [15:0] wr_data;

  int checks = 0;
  int fails = 0;
  int wr_seen = 0;
  logic [36:0] exp_q[$];

  always #10 clk = ~clk;

  muxbus_frontend #(.MIN_W(MIN_W)) uut (
    .clk(clk), .rst_n(rst_n), .adq_in(adq_in), .addr_hi(addr_hi), .ale_n(ale_n),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rd_word(rd_word), .status_sel(status_sel),
    .st_poll(st_poll), .st_toggle(st_toggle), .st_err(st_err), .bus_out(bus_out),
    .bus_oe(bus_oe), .word_addr(word_addr), .cycle(cycle), .wr_stb(wr_stb), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: scoreboard pop on every write pulse (R4)
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      wr_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {word_addr, wr_data}, '0);
      end else begin
        logic [36:0] e;
        e = exp_q.pop_front();
        chk({word_addr, wr_data} == e, "R4 write addr/data", {word_addr, wr_data}, e);
      end
    end
  end

  task automatic latch_addr(input logic [20:0] a);
    adq_in = a[15:0]; addr_hi = a[20:16]; ale_n = 1'b0;
    tick(2);
    ale_n = 1'b1;
    tick(4);
    chk(word_addr == a, "R2 address latched", word_addr, a);
  endtask

  // mode 0: we rises first, mode 1: ce rises first
  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input bit mode);
    latch_addr(a);
    adq_in = d;
    tick(1);
    ce_n = 1'b0; we_n = 1'b0;
    tick(MIN_W + 3);
    chk(cycle == 2'd3, "R3 write decode", cycle, 2'd3);
    chk(!bus_oe, "R6 no drive in write", bus_oe, 0);
    exp_q.push_back({a, d});
    if (!mode) begin
      we_n = 1'b1; tick(1); adq_in = ~d; tick(MIN_W + 4); ce_n = 1'b1;
    end else begin
      ce_n = 1'b1; tick(1); adq_in = ~d; tick(2); we_n = 1'b1; tick(MIN_W + 4);
    end
    tick(MIN_W + 3);
  endtask

  task automatic do_read(input logic [20:0] a, input bit ssel, input logic [15:0] exp_w);
    latch_addr(a);
    status_sel = ssel;
    ce_n = 1'b0; oe_n = 1'b0;
    tick(MIN_W + 3);
    chk(cycle == 2'd2, "R3 read decode", cycle, 2'd2);
    chk(bus_oe, "R6 drive in read", bus_oe, 1);
    chk(bus_out == exp_w, ssel ? "R8 status word" : "R7 array word", bus_out, exp_w);
    oe_n = 1'b1;
    tick(MIN_W + 3);
    chk(cycle == 2'd1 && !bus_oe && bus_out == 0, "R3 output-disable", {cycle, bus_oe, bus_out}, {2'd1, 1'b0, 16'h0});
    oe_n = 1'b0; ce_n = 1'b1;
    tick(MIN_W + 3);
    chk(cycle == 2'd0 && !bus_oe && bus_out == 0, "R6 standby ignores oe", {cycle, bus_oe, bus_out}, 0);
    oe_n = 1'b1;
    tick(MIN_W + 3);
  endtask

  initial begin
    int base;
    tick(3);
    chk(!bus_oe && cycle == 0 && !wr_stb && word_addr == 0, "R1 reset state", {cycle, bus_oe, wr_stb, word_addr}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!bus_oe && cycle == 0 && !wr_stb && word_addr == 0, "R1 after reset", {cycle, bus_oe, wr_stb, word_addr}, 0);

    latch_addr(21'h1F_0A5C);
    adq_in = 16'hDEAD;
    tick(5);
    chk(word_addr == 21'h1F_0A5C, "R2 address held", word_addr, 21'h1F_0A5C);

    do_write(21'h0A_1234, 16'hBEEF, 1'b0);
    do_write(21'h15_FFFF, 16'h0F0F, 1'b1);
    do_write(21'h00_0000, 16'hFFFF, 1'b0);

    rd_word = 16'hA55A;
    do_read(21'h03_3333, 1'b0, 16'hA55A);
    rd_word = 16'h1234; st_poll = 1'b1; st_toggle = 2'b10; st_err = 1'b0;
    do_read(21'h04_0001, 1'b1, 16'h00C0);
    st_poll = 1'b0; st_toggle = 2'b01; st_err = 1'b1;
    do_read(21'h04_0002, 1'b1, 16'h0024);
    status_sel = 1'b0;

    // R10 latency from pin to decoded cycle
    ce_n = 1'b0; oe_n = 1'b0;
    tick(1 + MIN_W);
    chk(cycle == 2'd0, "R10 not yet changed", cycle, 2'd0);
    tick(1);
    chk(cycle == 2'd2, "R10 changed on time", cycle, 2'd2);
    ce_n = 1'b1; oe_n = 1'b1;
    tick(MIN_W + 4);

    // R5 short write-enable pulse inside chip select
    base = wr_seen;
    ce_n = 1'b0;
    tick(MIN_W + 3);
    chk(cycle == 2'd1, "R5 output-disable before glitch", cycle, 2'd1);
    we_n = 1'b0; tick(MIN_W - 1); we_n = 1'b1;
    tick(1);
    tick(MIN_W + 2);
    chk(cycle == 2'd1 && wr_seen == base, "R5 short we ignored", {cycle, wr_seen[7:0]}, {2'd1, base[7:0]});
    // short high glitch on ce keeps the disabled state
    ce_n = 1'b1; tick(MIN_W - 1); ce_n = 1'b0;
    tick(MIN_W + 3);
    chk(cycle == 2'd1, "R5 short ce rise ignored", cycle, 2'd1);
    // short chip-select pulse while write enable is held low
    ce_n = 1'b1; tick(MIN_W + 3);
    we_n = 1'b0; tick(MIN_W + 3);
    ce_n = 1'b0; tick(MIN_W - 1); ce_n = 1'b1;
    tick(MIN_W + 4);
    chk(cycle == 2'd0 && wr_seen == base, "R5 short ce ignored", {cycle, wr_seen[7:0]}, {2'd0, base[7:0]});
    we_n = 1'b1; tick(MIN_W + 3);

    // R5 pulse of exactly MIN_W samples is a write
    latch_addr(21'h07_7777);
    adq_in = 16'h5A5A;
    ce_n = 1'b0;
    tick(MIN_W + 3);
    exp_q.push_back({21'h07_7777, 16'h5A5A});
    we_n = 1'b0; tick(MIN_W); we_n = 1'b1;
    tick(MIN_W + 4);
    chk(wr_seen == base + 1, "R5 minimum-width write accepted", wr_seen, base + 1);
    ce_n = 1'b1; tick(MIN_W + 3);

    // R9 all strobes low together
    base = wr_seen;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    tick(MIN_W + 3);
    chk(cycle == 2'd1 && !bus_oe && bus_out == 0, "R9 contention disables", {cycle, bus_oe, bus_out}, {2'd1, 1'b0, 16'h0});
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    tick(MIN_W + 4);
    chk(wr_seen == base, "R9 no write from contention", wr_seen, base);

    tick(5);
    chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule